// File: doc/BRIEF.md
# Fractional-Period Seconds Strobe

This block turns an input clock of any rate into a one-second strobe whose long-run average is exact, even when the number of input cycles per second is not a multiple of 256 or of any power of two. A free-running 8-bit prescaler marks every 256th enabled input cycle as a step. Each step takes 256 away from a 24-bit error accumulator by decrementing only its upper sixteen bits. When those upper bits reach zero, the block fires a one-cycle tick and adds the period constant back in. The low byte keeps its leftover remainder, so the fractional part carries into later seconds rather than being lost.

The period constant `PERIOD` is the number of enabled input cycles per second. A single second may run up to 255 cycles long or short, but over many seconds the total comes out exact. A slower poll strobe pulses whenever a step leaves the middle byte of the accumulator at zero. This is intended for sampling setting buttons. With a constant of 1,000,000 it runs at about 15 Hz.

Top module: `second_tick_gen`

## Requirements
- R1: While `rst_ni` is low, both strobes are low and the accumulator holds 0x000100. After release, the first tick follows the 256th enabled input cycle.
- R2: A cycle with `en_i` low changes no state and produces no strobe. A long stretch with `en_i` low neither drops nor adds counts.
- R3: Ticks occur only after a count of enabled cycles that is a multiple of 256. The prescaler is never cleared outside reset.
- R4: Counting enabled cycles from reset, tick number n (n starting at 1) is asserted in the cycle just after enabled cycle number 256*(floor(PERIOD*(n-1)/256)+1).
- R5: Between tick n and tick n+N, exactly N*PERIOD enabled cycles elapse whenever N*PERIOD is a multiple of 256.
- R6: Each single period between consecutive ticks differs from PERIOD by less than 256 enabled cycles.
- R7: `poll_o` is asserted in the cycle after every step that leaves bits [15:8] of the accumulator at zero, where the accumulator is taken as 0x000100 plus PERIOD times the ticks so far, minus 256 times the steps so far. It is asserted at no other time.
- R8: Every tick is accompanied by a poll pulse in the same cycle.
- R9: `tick_o` and `poll_o` are registered and never stay high for two consecutive cycles.
- R10: Asserting reset in the middle of a run restarts the timing from the reset state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; qualifies each input cycle |
| tick_o | output | 1 | One-cycle strobe, once per second |
| poll_o | output | 1 | One-cycle strobe for button sampling |

## Verification
On every cycle, the assertions check the following: the strobes are single-cycle, a tick always carries a poll, a disabled cycle leaves the accumulator and the strobes untouched, and the upper accumulator bits never sit at zero. Only the bench scenarios can show the arithmetic itself, which comes down to three things. Ticks must land on the exact enabled-cycle counts that the closed-form schedule predicts. Every group of four periods must sum to exactly four times the constant. Poll pulses must track the middle byte across a constant larger than 16 bits. A mid-run reset must restart that schedule from the beginning.

// File: rtl/second_tick_pkg.sv
package second_tick_pkg;
  parameter int unsigned DEF_ACC_W  = 24;
  parameter int unsigned DEF_PRE_W  = 8;
  parameter int unsigned DEF_MID_W  = 8;
  parameter int unsigned DEF_PERIOD = 32'h000F4240;
  localparam int unsigned STROBE_N  = 2;
  typedef enum int unsigned {
    STB_TICK = 0,
    STB_POLL = 1
  } strobe_idx_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic step_o
);
  logic [PRE_W-1:0] cnt_q;

  // free-running: only reset clears it, so no counts are lost between steps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + PRE_W'(1);
  end

  assign step_o = en_i & (&cnt_q);
endmodule

// File: rtl/tick_accum.sv
module tick_accum #(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned MID_W  = 8,
  parameter int unsigned PERIOD = 32'h000F4240
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic             hit_o,
  output logic             mid_zero_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int unsigned HI_W = ACC_W - PRE_W - MID_W;
  localparam int unsigned UP_W = ACC_W - PRE_W;
  localparam logic [ACC_W-1:0] K    = ACC_W'(PERIOD);
  localparam logic [PRE_W-1:0] K_LO = K[PRE_W-1:0];
  localparam logic [UP_W-1:0]  K_UP = K[ACC_W-1:PRE_W];

  logic [HI_W-1:0]  hi_q,  hi_dec;
  logic [MID_W-1:0] mid_q, mid_dec;
  logic [PRE_W-1:0] lo_q,  lo_sum;
  logic             lo_cy;
  logic [UP_W-1:0]  up_reload;

  always_comb begin
    mid_dec = mid_q - MID_W'(1);
    hi_dec  = (mid_q == '0) ? hi_q - HI_W'(1) : hi_q;   // borrow
    {lo_cy, lo_sum} = {1'b0, lo_q} + {1'b0, K_LO};
    up_reload = K_UP + UP_W'(lo_cy);
  end

  assign hit_o      = step_i && (hi_dec == '0) && (mid_dec == '0);
  assign mid_zero_o = step_i && (mid_dec == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      mid_q <= MID_W'(1);
      lo_q  <= '0;
    end else if (hit_o) begin
      {hi_q, mid_q} <= up_reload;
      lo_q          <= lo_sum;       // remainder kept
    end else if (step_i) begin
      hi_q  <= hi_dec;
      mid_q <= mid_dec;
    end
  end

  assign acc_o = {hi_q, mid_q, lo_q};
endmodule

// File: rtl/tick_strobe_reg.sv
module tick_strobe_reg #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_stb
    logic q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= 1'b0;
      else         q_q <= d_i[g];
    end
    assign q_o[g] = q_q;
  end
endmodule

// File: rtl/second_tick_gen.sv
module second_tick_gen
  import second_tick_pkg::*;
#(
  parameter int unsigned PERIOD = DEF_PERIOD,
  parameter int unsigned ACC_W  = DEF_ACC_W,
  parameter int unsigned PRE_W  = DEF_PRE_W,
  parameter int unsigned MID_W  = DEF_MID_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o,
  output logic poll_o
);
  logic             step_w;
  logic             hit_w;
  logic             mid_zero_w;
  logic [ACC_W-1:0] acc_w;
  logic [STROBE_N-1:0] stb_d, stb_q;

  tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step_o (step_w)
  );

  tick_accum #(
    .ACC_W(ACC_W), .PRE_W(PRE_W), .MID_W(MID_W), .PERIOD(PERIOD)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_w),
    .hit_o      (hit_w),
    .mid_zero_o (mid_zero_w),
    .acc_o      (acc_w)
  );

  always_comb begin
    stb_d           = '0;
    stb_d[STB_TICK] = hit_w;
    stb_d[STB_POLL] = mid_zero_w;
  end

  tick_strobe_reg #(.N(STROBE_N)) u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stb_d),
    .q_o    (stb_q)
  );

  assign tick_o = stb_q[STB_TICK];
  assign poll_o = stb_q[STB_POLL];
endmodule

// File: rtl/second_tick_gen_chk.sv
module second_tick_gen_chk #(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned PRE_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             step_i,
  input logic             tick_o,
  input logic             poll_o,
  input logic [ACC_W-1:0] acc_i
);
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R9
  AST_POLL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |=> !poll_o); // R9
  AST_TICK_WITH_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> poll_o); // R8
  AST_TICK_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(step_i)); // R3
  AST_IDLE_HOLDS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_i)); // R2
  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && !poll_o)); // R2
  AST_UPPER_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i[ACC_W-1:PRE_W] != '0); // R1
endmodule

bind second_tick_gen second_tick_gen_chk #(.ACC_W(ACC_W), .PRE_W(PRE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .step_i (step_w),
  .tick_o (tick_o),
  .poll_o (poll_o),
  .acc_i  (acc_w)
);

// File: tb/tb_second_tick_gen.sv
`timescale 1ns/1ps
module tb_second_tick_gen;
  localparam int unsigned K_A = 32'h00000A40;
  localparam int unsigned K_B = 32'h00012345;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic tick_a, poll_a, tick_b, poll_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  second_tick_gen #(.PERIOD(K_A)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .tick_o(tick_a), .poll_o(poll_a));
  second_tick_gen #(.PERIOD(K_B)) dut_poll (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .tick_o(tick_b), .poll_o(poll_b));

  longint kk [2];
  longint tk [2];
  longint st [2];
  longint ev [2];
  bit     et [2];
  bit     ep [2];
  longint hist [0:255];
  int     obs_n;
  bit     prev_tick, prev_poll;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 2; i++) begin
      tk[i] = 0; st[i] = 0; ev[i] = 0; et[i] = 1'b0; ep[i] = 1'b0;
    end
    obs_n = 0; prev_tick = 1'b0; prev_poll = 1'b0;
  endfunction

  function automatic void model_step(input bit e);
    for (int i = 0; i < 2; i++) begin
      et[i] = 1'b0; ep[i] = 1'b0;
      if (e) begin
        tk[i]++;
        if (tk[i] % 256 == 0) begin
          longint v;
          st[i]++;
          v = 256 + kk[i] * ev[i] - 256 * st[i];
          et[i] = (v < 256);
          ep[i] = (((v >> 8) & 255) == 0);
          if (et[i]) ev[i]++;
        end
      end
    end
  endfunction

  // at a negedge: compare outputs to expectations from the previous edge, then apply new enable
  task automatic cycle(input bit e);
    @(negedge clk);
    chk(tick_a == et[0], "R4 tick A", longint'(tick_a), longint'(et[0]));
    chk(poll_a == ep[0], "R7 poll A", longint'(poll_a), longint'(ep[0]));
    chk(tick_b == et[1], "R4 tick B", longint'(tick_b), longint'(et[1]));
    chk(poll_b == ep[1], "R7 poll B", longint'(poll_b), longint'(ep[1]));
    if (tick_a) begin
      longint expc;
      obs_n++;
      expc = 256 * ((kk[0] * longint'(obs_n - 1)) / 256 + 1);
      chk(tk[0] == expc, "R4 tick count", tk[0], expc);
      chk(tk[0] % 256 == 0, "R3 multiple of 256", tk[0] % 256, 0);
      chk(poll_a == 1'b1, "R8 poll with tick", longint'(poll_a), 1);
      if (obs_n <= 255) hist[obs_n] = tk[0];
      if (obs_n >= 2 && obs_n <= 255) begin
        longint d;
        d = hist[obs_n] - hist[obs_n-1] - kk[0];
        chk(d > -256 && d < 256, "R6 period jitter", hist[obs_n] - hist[obs_n-1], kk[0]);
      end
      if (obs_n >= 5 && obs_n <= 255 && ((obs_n - 1) % 4 == 0))
        chk(hist[obs_n] - hist[obs_n-4] == 4 * kk[0], "R5 four periods exact",
            hist[obs_n] - hist[obs_n-4], 4 * kk[0]);
    end
    if (prev_tick) chk(!tick_a, "R9 tick width", longint'(tick_a), 0);
    if (prev_poll) chk(!poll_b, "R9 poll width", longint'(poll_b), 0);
    prev_tick = tick_a;
    prev_poll = poll_b;
    en = e;
    model_step(e);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!tick_a && !poll_a && !tick_b && !poll_b, "R1 reset strobes low",
        longint'({tick_a, poll_a, tick_b, poll_b}), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      en = 1'($urandom_range(0, 1));
      chk(!tick_a && !poll_a, "R10 reset holds", longint'({tick_a, poll_a}), 0);
    end
    @(negedge clk);
    en = 1'b0;
    rst_ni = 1'b1;
    model_clear();
  endtask

  initial begin
    int idle_pulses;
    void'($urandom(32'd20240611));
    kk[0] = longint'(K_A);
    kk[1] = longint'(K_B);
    model_clear();
    apply_reset();                                                         // R1
    for (int i = 0; i < 256; i++) cycle(1'b1);                             // R1 first tick at 256
    for (int i = 0; i < 60000; i++) cycle(($urandom % 4) != 0);
    idle_pulses = 0;
    for (int i = 0; i < 700; i++) begin                                    // R2
      cycle(1'b0);
      if (tick_a || poll_a || tick_b || poll_b) idle_pulses++;
    end
    chk(idle_pulses == 0, "R2 idle no strobe", idle_pulses, 0);
    for (int i = 0; i < 20000; i++) cycle(1'(i & 1));
    chk(obs_n >= 10, "R5 enough ticks seen", obs_n, 10);
    apply_reset();                                                         // R10
    for (int i = 0; i < 66000; i++) cycle(($urandom % 10) < 7);
    chk(obs_n >= 10, "R10 ticks after restart", obs_n, 10);
    cycle(1'b0);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 190000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule